// File: doc/BRIEF.md
# Connector Seating Sequencer

This block watches the sense line of a hot-pluggable connector's seating contact. The line is pulled high while the device is absent and is grounded once the mating contact closes. From that line the block decides two things. The first is when the device may start its normal power-up work. The second is when a seated, running device is probably being pulled out. All delays are counted in milliseconds, using ticks from an internal prescaler.

A falling sense level starts a settling window of `SETTLE_MS` milliseconds. If the line goes open at any point in the window, the attempt is abandoned and the block waits for the next low level. When the window completes, the block also needs the configuration inputs (address selection and spin-up control) to have been sampled before it grants power-on permission. While running with removal detection enabled, an open level starts a filter of `REMOVE_MS` milliseconds. If the level is still open at the end of the filter, the block issues a one-cycle removal warning and withdraws permission. If the line returns low first, the open level is treated as a glitch.

States: `ST_UNSEATED` (line open, waiting), `ST_SETTLING` (counting the settle window), `ST_WAIT_CFG` (window done, configuration not yet sampled), `ST_RUNNING` (permission granted), `ST_DEPARTING` (filtering an open level), `ST_WARN` (one-cycle warning). Transitions:
- UNSEATED→SETTLING when the line is low.
- SETTLING→UNSEATED when the line is open.
- SETTLING→RUNNING or SETTLING→WAIT_CFG when the window ends, depending on `cfg_sampled`.
- WAIT_CFG→RUNNING when `cfg_sampled` is high.
- WAIT_CFG→UNSEATED when the line is open.
- RUNNING→DEPARTING when the line is open and detection is enabled.
- RUNNING→UNSEATED when the line is open and detection is disabled.
- DEPARTING→RUNNING when the line returns low.
- DEPARTING→WARN when the filter ends.
- WARN→UNSEATED always.

Top module: `seat_detect_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `power_ok`, `seated` and `remove_pulse` low from the next edge. After reset the block treats the sense line as open, so a line that is already low starts a fresh settling window.
- R2: `mate_sense_raw` passes through a two-flop synchroniser. A change on it has no effect on the outputs until the third rising edge, where the first edge that samples the new level counts as edge one.
- R3: A low sense level (low = mated, high = open) raises `seated` at the third edge that samples it. If `cfg_sampled` is high and the line stays low, `power_ok` rises at edge SETTLE_MS*CLKS_PER_MS+3.
- R4: An open level during the settling window drops `seated` at the third edge that samples it and abandons the count. A later low level restarts the full window.
- R5: If `cfg_sampled` is low when the window ends, `seated` stays high and `power_ok` stays low. `power_ok` then rises at the first edge that samples `cfg_sampled` high.
- R6: With `rm_det_en` high, an open level that persists in the running state gives `remove_pulse` high for exactly one cycle, at edge REMOVE_MS*CLKS_PER_MS+3. In that same cycle `power_ok` and `seated` go low.
- R7: With `rm_det_en` high, an open level that lasts fewer than REMOVE_MS*CLKS_PER_MS-1 cycles while running produces no pulse. `power_ok` and `seated` stay high throughout.
- R8: With `rm_det_en` low, an open level while running drops `power_ok` and `seated` at the third edge and never produces `remove_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mate_sense_raw | input | 1 | Raw seating sense, low = mated, high = open |
| cfg_sampled | input | 1 | High once the address and spin-up inputs have been sampled |
| rm_det_en | input | 1 | Enables the removal filter and warning |
| power_ok | output | 1 | Normal power-up processing permitted |
| seated | output | 1 | Device considered mated |
| remove_pulse | output | 1 | One-cycle likely-removal warning |

## Verification
The bench builds the block with CLKS_PER_MS=4, SETTLE_MS=10 and REMOVE_MS=3. This makes the settle window 40 cycles and the removal filter 12 cycles. At that scale every edge count in the requirements can be predicted exactly and checked on the cycle before and the cycle of each change. Aborted settling, glitches shorter than the filter, a delayed configuration flag and a reset while the line is held low all fit into a few hundred cycles.

// File: rtl/seat_detect_pkg.sv
package seat_detect_pkg;
    typedef enum logic [2:0] {
        ST_UNSEATED,
        ST_SETTLING,
        ST_WAIT_CFG,
        ST_RUNNING,
        ST_DEPARTING,
        ST_WARN
    } seat_state_t;
endpackage

// File: rtl/seat_sync.sv
module seat_sync #(
    parameter int  STAGES    = 2,
    parameter bit  RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
    parameter int CLKS_PER_MS = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int PW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_MS - 1);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)      cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/ms_window.sv
module ms_window #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] ms_cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) ms_cnt <= '0;
        else if (tick)  ms_cnt <= ms_cnt + 1'b1;
    end

    assign done = tick && (ms_cnt == limit - 1'b1);
endmodule

// File: rtl/seat_detect_seq.sv
module seat_detect_seq
    import seat_detect_pkg::*;
#(
    parameter int CLKS_PER_MS = 100000,
    parameter int SETTLE_MS   = 250,
    parameter int REMOVE_MS   = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic mate_sense_raw,
    input  logic cfg_sampled,
    input  logic rm_det_en,
    output logic power_ok,
    output logic seated,
    output logic remove_pulse
);
    localparam int MAX_MS = (SETTLE_MS > REMOVE_MS) ? SETTLE_MS : REMOVE_MS;
    localparam int WW     = $clog2(MAX_MS + 1);
    localparam logic [WW-1:0] SETTLE_LIM = WW'(SETTLE_MS);
    localparam logic [WW-1:0] REMOVE_LIM = WW'(REMOVE_MS);

    seat_state_t state, state_nx;
    logic        line_open;
    logic        ms_tick;
    logic        win_done;
    logic        restart;
    logic [WW-1:0] win_limit;

    seat_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (mate_sense_raw),
        .dout(line_open)
    );

    assign restart   = (state_nx != state);
    assign win_limit = (state == ST_DEPARTING) ? REMOVE_LIM : SETTLE_LIM;

    ms_tick_gen #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
        .clk (clk),
        .rst (rst),
        .clr (restart),
        .tick(ms_tick)
    );

    ms_window #(.W(WW)) u_window (
        .clk  (clk),
        .rst  (rst),
        .clr  (restart),
        .tick (ms_tick),
        .limit(win_limit),
        .done (win_done)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_UNSEATED;
        else     state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_UNSEATED:  if (!line_open) state_nx = ST_SETTLING;
            ST_SETTLING: begin
                if (line_open)     state_nx = ST_UNSEATED;
                else if (win_done) state_nx = cfg_sampled ? ST_RUNNING : ST_WAIT_CFG;
            end
            ST_WAIT_CFG: begin
                if (line_open)        state_nx = ST_UNSEATED;
                else if (cfg_sampled) state_nx = ST_RUNNING;
            end
            ST_RUNNING:   if (line_open) state_nx = rm_det_en ? ST_DEPARTING : ST_UNSEATED;
            ST_DEPARTING: begin
                if (!line_open)    state_nx = ST_RUNNING;
                else if (win_done) state_nx = ST_WARN;
            end
            ST_WARN:      state_nx = ST_UNSEATED;
            default:      state_nx = ST_UNSEATED;
        endcase
    end

    // Outputs
    always_comb begin
        power_ok     = 1'b0;
        seated       = 1'b0;
        remove_pulse = 1'b0;
        unique case (state)
            ST_UNSEATED:  ;
            ST_SETTLING:  seated = 1'b1;
            ST_WAIT_CFG:  seated = 1'b1;
            ST_RUNNING:   begin seated = 1'b1; power_ok = 1'b1; end
            ST_DEPARTING: begin seated = 1'b1; power_ok = 1'b1; end
            ST_WARN:      remove_pulse = 1'b1;
            default:      ;
        endcase
    end
endmodule

// File: rtl/seat_detect_seq_chk.sv
module seat_detect_seq_chk (
    input logic clk,
    input logic rst,
    input logic cfg_sampled,
    input logic power_ok,
    input logic seated,
    input logic remove_pulse
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!power_ok && !seated && !remove_pulse));

    assert_permit_needs_seat_R3: assert property (@(posedge clk) disable iff (rst)
        power_ok |-> seated);

    assert_permit_after_settle_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(power_ok) |-> $past(seated));

    assert_permit_needs_cfg_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(power_ok) |-> $past(cfg_sampled));

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
        remove_pulse |=> !remove_pulse);

    assert_pulse_drops_permit_R6: assert property (@(posedge clk) disable iff (rst)
        remove_pulse |-> (!power_ok && !seated));

    assert_pulse_after_running_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(remove_pulse) |-> $past(power_ok));
endmodule

bind seat_detect_seq seat_detect_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_sampled (cfg_sampled),
    .power_ok    (power_ok),
    .seated      (seated),
    .remove_pulse(remove_pulse)
);

// File: tb/seat_detect_seq_bench.sv
module seat_detect_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CPM = 4;
    localparam int SMS = 10;
    localparam int RMS = 3;
    localparam int SC  = SMS * CPM;
    localparam int RC  = RMS * CPM;

    logic clk = 1'b0;
    logic rst, raw, cfg, en;
    logic power_ok, seated, remove_pulse;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        bit    pok;
        bit    seat;
        bit    pls;
        string tag;
    } exp_t;
    exp_t q[$];

    seat_detect_seq #(.CLKS_PER_MS(CPM), .SETTLE_MS(SMS), .REMOVE_MS(RMS)) u_seat_detect_seq (
        .clk(clk), .rst(rst), .mate_sense_raw(raw), .cfg_sampled(cfg), .rm_det_en(en),
        .power_ok(power_ok), .seated(seated), .remove_pulse(remove_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int at, input bit p, input bit s, input bit u, input string tag);
        exp_t e;
        e.at = at; e.pok = p; e.seat = s; e.pls = u; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare outputs against expected items when their cycle arrives
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            exp_t it;
            it = q.pop_front();
            checks++;
            if (it.at < cyc) begin
                errors++;
                $display("FAIL %s: item for cycle %0d missed (now %0d)", it.tag, it.at, cyc);
            end else if (power_ok !== it.pok || seated !== it.seat || remove_pulse !== it.pls) begin
                errors++;
                $display("FAIL %s @%0d: actual pok=%b seat=%b pulse=%b expected pok=%b seat=%b pulse=%b",
                         it.tag, cyc, power_ok, seated, remove_pulse, it.pok, it.seat, it.pls);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        int n;
        rst = 1'b1; raw = 1'b1; cfg = 1'b0; en = 1'b0;
        step(1);
        push(cyc + 1, 0, 0, 0, "R1 reset");
        step(2);
        rst = 1'b0;
        step(2);

        // R2/R3: settle with configuration already sampled
        cfg = 1'b1; en = 1'b1;
        n = cyc; raw = 1'b0;
        push(n + 2,      0, 0, 0, "R2 sync latency");
        push(n + 3,      0, 1, 0, "R3 seated");
        push(n + 2 + SC, 0, 1, 0, "R3 before window end");
        push(n + 3 + SC, 1, 1, 0, "R3 permit");
        drain();

        // R6: persistent open level with detection enabled
        n = cyc; raw = 1'b1;
        push(n + 2,      1, 1, 0, "R2 open latency");
        push(n + 2 + RC, 1, 1, 0, "R6 before filter end");
        push(n + 3 + RC, 0, 0, 1, "R6 warning");
        push(n + 4 + RC, 0, 0, 0, "R6 single cycle");
        drain();

        // R4: abort during settling, then full restart
        n = cyc; raw = 1'b0;
        push(n + 3, 0, 1, 0, "R4 seated");
        step(5);
        n = cyc; raw = 1'b1;
        push(n + 3, 0, 0, 0, "R4 abort");
        drain();
        step(3);
        n = cyc; raw = 1'b0;
        push(n + 2 + SC, 0, 1, 0, "R4 full restart not early");
        push(n + 3 + SC, 1, 1, 0, "R4 restart permit");
        drain();

        // R7: short open level filtered as a glitch
        n = cyc; raw = 1'b1;
        push(n + 3, 1, 1, 0, "R7 open filtering");
        step(RC - 2);
        raw = 1'b0;
        push(n + 3 + RC, 1, 1, 0, "R7 no warning");
        push(n + 4 + RC, 1, 1, 0, "R7 no warning after");
        push(n + 30,     1, 1, 0, "R7 still permitted");
        drain();

        // R8: detection disabled
        en = 1'b0;
        n = cyc; raw = 1'b1;
        push(n + 2,      1, 1, 0, "R8 before drop");
        push(n + 3,      0, 0, 0, "R8 drop");
        push(n + 3 + RC, 0, 0, 0, "R8 no pulse");
        push(n + 4 + RC, 0, 0, 0, "R8 no pulse later");
        drain();

        // R5: configuration sampled late
        en = 1'b1; cfg = 1'b0;
        n = cyc; raw = 1'b0;
        push(n + 3 + SC, 0, 1, 0, "R5 waiting for config");
        push(n + 8 + SC, 0, 1, 0, "R5 still waiting");
        drain();
        n = cyc; cfg = 1'b1;
        push(n,     0, 1, 0, "R5 before config edge");
        push(n + 1, 1, 1, 0, "R5 permit on config");
        drain();

        // R1: reset while running and line held low
        n = cyc; rst = 1'b1;
        push(n + 1, 0, 0, 0, "R1 mid-run reset");
        step(2);
        n = cyc; rst = 1'b0;
        push(n + 2,      0, 0, 0, "R1 line treated open");
        push(n + 3,      0, 1, 0, "R1 fresh window");
        push(n + 3 + SC, 1, 1, 0, "R1 permit after reset");
        drain();

        finish_run();
    end
endmodule